// File: doc/BRIEF.md
# Message record/playback sequencer

This block is the digital controller for a segmented voice message store. The store is split into 160 equal segments. A timebase marks the end of each segment with a one-clock strobe. The controller keeps a pointer to the current segment and one end-of-message marker bit per segment. A host starts record and playback cycles by driving a falling edge on an active-low chip-enable. The analog array, the filters and the speaker path sit outside this block. They follow the record-enable, play-enable and auxiliary-select outputs.

The 8-bit bus has two uses. It can carry a start address. When its two top bits are both 1, it carries a word of six mode flags instead. The flags change how the pointer and the markers behave, whether chip-enable acts on its edge or on its level, and when the active-low end-of-message output pulses. Several flags can be set at once. A power-down input and a low-supply flag override normal operation. A separate clear input empties the marker store. Debug outputs show the pointer and the active flags.

Top module: `msg_seq_ctrl`

## Requirements
- R1: A falling `ce_n` while idle latches the bus and `play_sel`: 1 selects playback and 0 selects record. In address use (bus bits 7 and 6 not both 1), the pointer loads the bus value, and a value of 160 or more loads 0.
- R2: When bus bits 7 and 6 are both 1, the bus is a mode word and bit i (i = 0..5) enables mode Mi: M0 cue, M1 join, M2 cascade, M3 loop, M4 consecutive, M5 level chip-enable. The flags appear on `dbg_modes`, bit i for Mi. They hold until the next falling `ce_n`, and an address operation clears them.
- R3: While a cycle is active, each `seg_tick` advances the pointer by exactly one. The pointer never leaves 0..159.
- R4: `rec_en` is high during a record cycle while `ce_n` stays low, and `play_en` and `aux_sel` stay low. Each tick clears the marker of the current segment. When `ce_n` or `pwr_dn` rises, a marker is written at the current segment. A rise of `ce_n` also moves the pointer to the next segment (159 wraps to 0).
- R5: Default playback starts on the edge and ignores a later rise of `ce_n`. On the tick of a segment that holds a marker, playback stops, `eom_n` goes low for EOM_CYC clocks, and the pointer returns to 0. `aux_sel` is then high while `ce_n` is high.
- R6: A tick on segment 159 that does not end the cycle another way means the store is full. Record and play stop, `eom_n` pulses (M2 does not suppress this pulse), `aux_sel` goes high and the pointer stays at 159. Falling `ce_n` is ignored until `pwr_dn` is raised.
- R7: `pwr_dn` high ends any cycle and sets the pointer to 0. On the next clock, `rec_en`, `play_en` and `aux_sel` are all low.
- R8: A mode-word playback that directly follows a record starts at segment 0. Otherwise it starts at the current pointer. With M4, reaching a marker moves the pointer to the segment after the marker instead of to 0.
- R9: M0 playback makes no sound. The pointer scans forward one segment per clock to the first marker at or after it and stops on the segment after that marker. If no marker is found, the pointer goes to 0.
- R10: An M1 record that starts with the pointer above 0 clears the marker just before the pointer. This joins the new message to the previous one.
- R11: With M2, a marker stops playback without an `eom_n` pulse. With M3, playback starts at 0, and a marker sends the pointer back to 0 while playback continues and the pulse is still given.
- R12: M5 playback starts at segment 0 and stops when `ce_n` rises. The pointer keeps its value.
- R13: While `supply_low` is high, `eom_n` is held low and a falling `ce_n` with record selected starts nothing. Playback can still start.
- R14: A one-clock `mk_clear` pulse clears every marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mk_clear | input | 1 | Synchronous clear of all markers |
| ce_n | input | 1 | Active-low chip-enable |
| play_sel | input | 1 | 1 = playback, 0 = record; latched on falling `ce_n` |
| pwr_dn | input | 1 | Power-down |
| addr_mode | input | 8 | Start address or mode word |
| seg_tick | input | 1 | One-clock strobe at the end of each segment |
| supply_low | input | 1 | Low-supply flag |
| eom_n | output | 1 | Active-low end-of-message pulse |
| rec_en | output | 1 | Record path enable |
| play_en | output | 1 | Playback path enable |
| aux_sel | output | 1 | Route the auxiliary input to the speaker |
| dbg_ptr | output | 8 | Current segment pointer |
| dbg_modes | output | 6 | Active mode flags, bit i = Mi |

## Verification
A wrong pointer shows on `dbg_ptr` one clock after the tick or edge that caused it. It also shows when playback stops on a different tick than the marker layout predicts. A lost or misplaced marker is exposed by the next playback over that segment: the stop, and the `eom_n` fall that comes with it, arrive on the wrong tick, or the store overflows. That is checked against a marker model kept in the bench. Wrong mode flags show on `dbg_modes` right after the edge, and at the port they show as a pointer landing on the wrong segment or a pulse that should not be there.

// File: rtl/msg_seq_pkg.sv
`timescale 1ns/1ps
package msg_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REC,
    ST_PLAY,
    ST_CUE,
    ST_FULL
  } seq_state_t;

  // mode flag positions within the mode word
  localparam int M_CUE    = 0;
  localparam int M_JOIN   = 1;
  localparam int M_CASC   = 2;
  localparam int M_LOOP   = 3;
  localparam int M_CONSEC = 4;
  localparam int M_LEVEL  = 5;
endpackage

// File: rtl/msg_marker_file.sv
`timescale 1ns/1ps
module msg_marker_file #(
  parameter int NUM_SEG = 160,
  parameter int PTR_W   = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic             wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic             rd
);
  logic [NUM_SEG-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst || clr) bits_q <= '0;
    else if (we)    bits_q[waddr] <= wdata;
  end

  assign rd = bits_q[raddr];

  // R14
  mk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (bits_q == '0));
endmodule

// File: rtl/msg_eom_pulse.sv
`timescale 1ns/1ps
module msg_eom_pulse #(
  parameter int EOM_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic hold_low,
  output logic eom_n
);
  localparam int CW = $clog2(EOM_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    if (trig)              cnt_n = CW'(EOM_CYC);
    else if (cnt_q != '0)  cnt_n = cnt_q - CW'(1);
    else                   cnt_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      eom_n <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      eom_n <= !(hold_low || (cnt_n != '0));
    end
  end

  // R5
  eom_start_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> !eom_n);
  // R13
  eom_supply_chk: assert property (@(posedge clk) disable iff (rst)
    hold_low |=> !eom_n);
endmodule

// File: rtl/msg_seq_fsm.sv
`timescale 1ns/1ps
module msg_seq_fsm
  import msg_seq_pkg::*;
#(
  parameter int NUM_SEG = 160,
  parameter int BUS_W   = 8,
  parameter int PTR_W   = $clog2(NUM_SEG),
  parameter int NMODE   = BUS_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_n,
  input  logic             play_sel,
  input  logic             pwr_dn,
  input  logic [BUS_W-1:0] addr_mode,
  input  logic             seg_tick,
  input  logic             supply_low,
  input  logic             mk_rd,
  output logic             mk_we,
  output logic [PTR_W-1:0] mk_waddr,
  output logic             mk_wdata,
  output logic             eom_trig,
  output logic             rec_en,
  output logic             play_en,
  output logic             aux_sel,
  output logic [PTR_W-1:0] ptr,
  output logic [NMODE-1:0] modes
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_SEG - 1);

  seq_state_t       st, st_n;
  logic [PTR_W-1:0] ptr_n, ptr_inc, start_addr;
  logic [NMODE-1:0] modes_n, flags;
  logic             last_rec, last_rec_n;
  logic             ce_q, ce_fall, is_word;

  assign ce_fall    = ce_q && !ce_n;
  assign is_word    = addr_mode[BUS_W-1] && addr_mode[BUS_W-2];
  assign flags      = is_word ? addr_mode[NMODE-1:0] : '0;
  assign start_addr = (addr_mode < BUS_W'(NUM_SEG)) ? addr_mode[PTR_W-1:0] : '0;
  assign ptr_inc    = (ptr == LAST) ? '0 : ptr + PTR_W'(1);

  always_comb begin
    st_n       = st;
    ptr_n      = ptr;
    modes_n    = modes;
    last_rec_n = last_rec;
    mk_we      = 1'b0;
    mk_waddr   = ptr;
    mk_wdata   = 1'b0;
    eom_trig   = 1'b0;
    if (pwr_dn) begin
      if (st == ST_REC) begin
        mk_we    = 1'b1;
        mk_wdata = 1'b1;
      end
      st_n  = ST_IDLE;
      ptr_n = '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (ce_fall) begin
            modes_n = flags;
            if (play_sel) begin
              last_rec_n = 1'b0;
              if (!is_word) begin
                ptr_n = start_addr;
                st_n  = ST_PLAY;
              end else begin
                ptr_n = (last_rec || flags[M_LOOP] || flags[M_LEVEL]) ? '0 : ptr;
                st_n  = flags[M_CUE] ? ST_CUE : ST_PLAY;
              end
            end else if (!supply_low) begin
              last_rec_n = 1'b1;
              st_n       = ST_REC;
              if (!is_word) begin
                ptr_n = start_addr;
              end else if (flags[M_JOIN] && (ptr != '0)) begin
                mk_we    = 1'b1;
                mk_waddr = ptr - PTR_W'(1);
                mk_wdata = 1'b0;
              end
            end
          end
        end
        ST_REC: begin
          if (ce_n) begin
            mk_we    = 1'b1;
            mk_wdata = 1'b1;
            ptr_n    = ptr_inc;
            st_n     = ST_IDLE;
          end else if (seg_tick) begin
            mk_we = 1'b1;
            if (ptr == LAST) begin
              st_n     = ST_FULL;
              eom_trig = 1'b1;
            end else begin
              ptr_n = ptr + PTR_W'(1);
            end
          end
        end
        ST_PLAY: begin
          if (modes[M_LEVEL] && ce_n) begin
            st_n = ST_IDLE;
          end else if (seg_tick) begin
            if (mk_rd) begin
              eom_trig = !modes[M_CASC];
              if (modes[M_LOOP]) begin
                ptr_n = '0;
              end else begin
                st_n  = ST_IDLE;
                ptr_n = modes[M_CONSEC] ? ptr_inc : '0;
              end
            end else if (ptr == LAST) begin
              st_n     = ST_FULL;
              eom_trig = 1'b1;
            end else begin
              ptr_n = ptr + PTR_W'(1);
            end
          end
        end
        ST_CUE: begin
          if (mk_rd) begin
            ptr_n = ptr_inc;
            st_n  = ST_IDLE;
          end else if (ptr == LAST) begin
            ptr_n = '0;
            st_n  = ST_IDLE;
          end else begin
            ptr_n = ptr + PTR_W'(1);
          end
        end
        ST_FULL: st_n = ST_FULL;
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ptr      <= '0;
      modes    <= '0;
      last_rec <= 1'b0;
      ce_q     <= 1'b1;
      rec_en   <= 1'b0;
      play_en  <= 1'b0;
      aux_sel  <= 1'b0;
    end else begin
      st       <= st_n;
      ptr      <= ptr_n;
      modes    <= modes_n;
      last_rec <= last_rec_n;
      ce_q     <= ce_n;
      rec_en   <= (st_n == ST_REC);
      play_en  <= (st_n == ST_PLAY);
      aux_sel  <= !pwr_dn && ((ce_n && (st_n != ST_PLAY) && (st_n != ST_REC))
                              || (st_n == ST_FULL));
    end
  end

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);
  // R7
  pwr_dn_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> (ptr == '0) && !rec_en && !play_en && !aux_sel);
  // R4
  rec_mute_chk: assert property (@(posedge clk) disable iff (rst)
    rec_en |-> !aux_sel && !play_en);
  // R13
  no_low_rec_chk: assert property (@(posedge clk) disable iff (rst)
    (supply_low && (st == ST_IDLE)) |=> !rec_en);
  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_FULL) && !pwr_dn) |=> (ptr == LAST) && aux_sel);
endmodule

// File: rtl/msg_seq_ctrl.sv
`timescale 1ns/1ps
module msg_seq_ctrl #(
  parameter int NUM_SEG = 160,
  parameter int BUS_W   = 8,
  parameter int EOM_CYC = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mk_clear,
  input  logic                       ce_n,
  input  logic                       play_sel,
  input  logic                       pwr_dn,
  input  logic [BUS_W-1:0]           addr_mode,
  input  logic                       seg_tick,
  input  logic                       supply_low,
  output logic                       eom_n,
  output logic                       rec_en,
  output logic                       play_en,
  output logic                       aux_sel,
  output logic [$clog2(NUM_SEG)-1:0] dbg_ptr,
  output logic [BUS_W-3:0]           dbg_modes
);
  localparam int PTR_W = $clog2(NUM_SEG);
  localparam int NMODE = BUS_W - 2;

  logic             mk_rd, mk_we, mk_wdata, eom_trig;
  logic [PTR_W-1:0] mk_waddr, ptr;
  logic [NMODE-1:0] modes;

  msg_seq_fsm #(.NUM_SEG(NUM_SEG), .BUS_W(BUS_W), .PTR_W(PTR_W), .NMODE(NMODE)) u_fsm (
    .clk(clk), .rst(rst), .ce_n(ce_n), .play_sel(play_sel), .pwr_dn(pwr_dn),
    .addr_mode(addr_mode), .seg_tick(seg_tick), .supply_low(supply_low),
    .mk_rd(mk_rd), .mk_we(mk_we), .mk_waddr(mk_waddr), .mk_wdata(mk_wdata),
    .eom_trig(eom_trig), .rec_en(rec_en), .play_en(play_en), .aux_sel(aux_sel),
    .ptr(ptr), .modes(modes)
  );

  msg_marker_file #(.NUM_SEG(NUM_SEG), .PTR_W(PTR_W)) u_markers (
    .clk(clk), .rst(rst), .clr(mk_clear), .we(mk_we), .waddr(mk_waddr),
    .wdata(mk_wdata), .raddr(ptr), .rd(mk_rd)
  );

  msg_eom_pulse #(.EOM_CYC(EOM_CYC)) u_eom (
    .clk(clk), .rst(rst), .trig(eom_trig), .hold_low(supply_low), .eom_n(eom_n)
  );

  assign dbg_ptr   = ptr;
  assign dbg_modes = modes;
endmodule

// File: tb/msg_seq_ctrl_bench.sv
`timescale 1ns/1ps
module msg_seq_ctrl_bench;
  localparam int EOM_CYC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1, mk_clear = 1'b0, ce_n = 1'b1, play_sel = 1'b1, pwr_dn = 1'b0;
  logic seg_tick = 1'b0, supply_low = 1'b0;
  logic [7:0] addr_mode = '0;
  logic eom_n, rec_en, play_en, aux_sel;
  logic [7:0] dbg_ptr;
  logic [5:0] dbg_modes;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [159:0] shadow;

  always #5 clk = ~clk;

  msg_seq_ctrl #(.EOM_CYC(EOM_CYC)) u_msg_seq_ctrl (
    .clk(clk), .rst(rst), .mk_clear(mk_clear), .ce_n(ce_n), .play_sel(play_sel),
    .pwr_dn(pwr_dn), .addr_mode(addr_mode), .seg_tick(seg_tick),
    .supply_low(supply_low), .eom_n(eom_n), .rec_en(rec_en), .play_en(play_en),
    .aux_sel(aux_sel), .dbg_ptr(dbg_ptr), .dbg_modes(dbg_modes)
  );

  function automatic logic [7:0] mword(input logic [5:0] f);
    return {2'b11, f};
  endfunction

  // first marker at or after s in the bench model, -1 when the store overflows
  function automatic int stop_seg(input int s);
    for (int k = s; k < 160; k++) if (shadow[k]) return k;
    return -1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick();
    seg_tick = 1'b1;
    step();
    seg_tick = 1'b0;
  endtask

  task automatic start(input bit play, input logic [7:0] bus, input bit pulse);
    ce_n = 1'b0; play_sel = play; addr_mode = bus;
    step();
    if (pulse) ce_n = 1'b1;
  endtask

  task automatic ce_up();
    ce_n = 1'b1;
    step();
  endtask

  task automatic pwr_pulse();
    pwr_dn = 1'b1;
    step();
    chk("R7 ptr after power-down", dbg_ptr, 0);
    chk("R7 outputs off after power-down", {rec_en, play_en, aux_sel}, 0);
    pwr_dn = 1'b0;
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: all requirements, actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    step(); step(); step();
    rst = 1'b0;
    step();
    chk("reset rec/play off", {rec_en, play_en}, 0);
    chk("reset eom_n high", eom_n, 1);
    chk("R3 reset pointer", dbg_ptr, 0);
    chk("R2 reset modes", dbg_modes, 0);

    // R1 R4 record at segment 10
    start(0, 8'd10, 0);
    chk("R1 record start address", dbg_ptr, 10);
    chk("R4 rec_en during record", rec_en, 1);
    chk("R4 speaker muted in record", {aux_sel, play_en}, 0);
    repeat (3) tick();
    chk("R3 pointer after 3 ticks", dbg_ptr, 13);
    ce_up();
    chk("R4 record ended", rec_en, 0);
    chk("R4 pointer after marker", dbg_ptr, 14);

    // R5 default playback from 10, marker at 13
    start(1, 8'd10, 1);
    chk("R5 play starts on edge", play_en, 1);
    repeat (3) tick();
    chk("R5 play ignores ce rise", play_en, 1);
    chk("R5 muted aux while playing", aux_sel, 0);
    chk("R3 play pointer", dbg_ptr, 13);
    tick();
    chk("R5 play stops at marker", play_en, 0);
    chk("R5 eom low at marker", eom_n, 0);
    chk("R5 pointer reset at marker", dbg_ptr, 0);
    chk("R5 aux after play end", aux_sel, 1);
    repeat (EOM_CYC - 1) step();
    chk("R5 eom still low", eom_n, 0);
    step();
    chk("R5 eom pulse ends", eom_n, 1);

    // R1 out-of-range address
    start(1, 8'd170, 1);
    chk("R1 address >=160 loads 0", dbg_ptr, 0);
    chk("R2 address op clears modes", dbg_modes, 0);
    pwr_pulse();

    // R6 overflow
    start(0, 8'd158, 0);
    tick();
    chk("R3 pointer at last segment", dbg_ptr, 159);
    tick();
    chk("R6 record stops on full", rec_en, 0);
    chk("R6 pointer held at 159", dbg_ptr, 159);
    chk("R6 eom on full", eom_n, 0);
    chk("R6 aux on full", aux_sel, 1);
    ce_up();
    start(1, 8'd5, 1);
    chk("R6 ce ignored when full", {play_en, dbg_ptr}, 159);
    pwr_pulse();
    repeat (EOM_CYC) step();

    // R14 clear markers: old marker at 13 no longer stops playback
    mk_clear = 1'b1; step(); mk_clear = 1'b0;
    start(1, 8'd13, 1);
    tick();
    chk("R14 marker cleared, play continues", {play_en, dbg_ptr}, 256 + 14);
    pwr_pulse();

    // R2 R8 consecutive mode
    start(0, mword(6'h10), 0);
    chk("R2 mode flags shown", dbg_modes, 6'h10);
    repeat (2) tick();
    ce_up();
    chk("R4 mode record pointer", dbg_ptr, 3);
    start(0, mword(6'h10), 0);
    chk("R8 record keeps pointer", dbg_ptr, 3);
    tick(); ce_up();
    start(1, mword(6'h10), 1);
    chk("R8 play after record starts at 0", dbg_ptr, 0);
    repeat (2) tick();
    chk("R8 playing", play_en, 1);
    tick();
    chk("R8 M4 pointer past marker", dbg_ptr, 3);
    chk("R8 M4 stop with eom", {play_en, eom_n}, 0);
    repeat (EOM_CYC) step();
    start(1, mword(6'h10), 1);
    chk("R8 play continues from pointer", dbg_ptr, 3);
    repeat (2) tick();
    chk("R8 second message end", {play_en, dbg_ptr}, 5);
    repeat (EOM_CYC) step();

    // R9 cueing
    pwr_pulse();
    start(1, mword(6'h11), 1);
    chk("R9 cue is silent", play_en, 0);
    repeat (4) step();
    chk("R9 cue to next message", dbg_ptr, 3);
    start(1, mword(6'h11), 1);
    repeat (4) step();
    chk("R9 cue again", dbg_ptr, 5);
    chk("R2 combined flags", dbg_modes, 6'h11);

    // R10 join
    mk_clear = 1'b1; step(); mk_clear = 1'b0;
    pwr_pulse();
    start(0, mword(6'h02), 0); repeat (2) tick(); ce_up();
    start(0, mword(6'h02), 0); tick(); ce_up();
    chk("R10 pointer after joined record", dbg_ptr, 5);
    start(1, mword(6'h00), 1);
    repeat (4) tick();
    chk("R10 joined message plays on", {play_en, dbg_ptr}, 256 + 4);
    tick();
    chk("R10 single marker at end", {play_en, eom_n, dbg_ptr}, 0);
    repeat (EOM_CYC) step();

    // R11 cascade and loop
    start(1, mword(6'h04), 1);
    repeat (5) tick();
    chk("R11 M2 stops without eom", {play_en, eom_n}, 1);
    start(1, mword(6'h08), 1);
    repeat (5) tick();
    chk("R11 M3 loops to 0", {play_en, eom_n, dbg_ptr}, 512);
    tick();
    chk("R11 M3 continues", {play_en, dbg_ptr}, 256 + 1);
    pwr_pulse();
    repeat (EOM_CYC) step();

    // R12 level chip-enable
    start(1, mword(6'h20), 0);
    tick();
    chk("R12 level play runs", {play_en, dbg_ptr}, 256 + 1);
    ce_up();
    chk("R12 ce rise stops play", {play_en, dbg_ptr}, 1);
    pwr_pulse();

    // R13 low supply
    supply_low = 1'b1;
    step();
    chk("R13 eom held low", eom_n, 0);
    start(0, 8'd20, 0);
    chk("R13 record refused", {rec_en, dbg_ptr}, 0);
    ce_up();
    start(1, 8'd20, 1);
    chk("R13 playback allowed", {play_en, dbg_ptr}, 256 + 20);
    pwr_pulse();
    supply_low = 1'b0;
    step();
    chk("R13 eom released", eom_n, 1);

    // random record/play against the bench marker model
    mk_clear = 1'b1; step(); mk_clear = 1'b0;
    shadow = '0;
    for (int it = 0; it < 24; it++) begin
      int a, len, s, m, n;
      pwr_pulse();
      a   = $urandom_range(0, 150);
      len = $urandom_range(0, 5);
      start(0, 8'(a), 0);
      for (int t = 0; t < len; t++) begin
        tick();
        shadow[a + t] = 1'b0;
      end
      ce_up();
      shadow[a + len] = 1'b1;
      chk("R4 random record pointer", dbg_ptr, a + len + 1);
      s = $urandom_range(0, a + len);
      m = stop_seg(s);
      n = (m < 0) ? (160 - s) : (m - s + 1);
      start(1, 8'(s), 1);
      for (int t = 0; t < n - 1; t++) tick();
      chk("R3 random play pointer", {play_en, dbg_ptr}, 256 + s + n - 1);
      tick();
      if (m < 0) chk("R6 random overflow", {play_en, eom_n, dbg_ptr}, 159);
      else       chk("R5 random stop at marker", {play_en, eom_n, dbg_ptr}, 0);
      repeat (EOM_CYC) step();
    end

    finish_run();
  end
endmodule